// File: doc/BRIEF.md
# I2C Sub-Addressed Transaction Sequencer

This block runs one whole I2C master transaction, read or write, against a device with a 7-bit address. It sits above a byte-level bus engine. It turns a transaction request into a string of single-byte engine commands: the address byte, zero to two register-offset (subaddress) bytes, a repeated START with a fresh address byte when a read follows an offset, and then the data bytes. A command can ask for a START before the byte, a STOP after it, a receive instead of a transmit, and a NAK reply for a received byte. The engine reports each finished byte with a one-cycle `eng_done` pulse and its status flags.

Write data enters on a valid/ready byte stream. A byte moves when `wr_valid` and `wr_ready` are both high on a clock edge. The sequencer takes a byte only when it can hand it straight to the engine, and the source may hold `wr_valid` low for as long as it likes. Read data leaves on a second valid/ready stream. Once `rd_valid` is raised, it and `rd_data` stay unchanged until `rd_ready` is seen high. No further receive command goes out while a byte is waiting, so the sink controls the pace of the bus.

When the transaction ends, the phase output shows done or failed. The residue output gives the number of data bytes that were not transferred, and an error code gives the cause of a failure. If a timeout or error arrives while the engine still holds the bus, the sequencer first sends an abort STOP. A bus found stuck at the next start gets a one-cycle unit reset before addressing begins. The engine itself ends the bus with a STOP when a slave refuses a byte.

Top module: `i2c_txn_seq`

## Requirements
- R1: The first command of every transaction carries START, and its byte is `{dev_addr, rw}`: bit 0 is 1 for a read and 0 for a write, and bits 7:1 hold the device address.
- R2: When `sub_len` is 1 or 2, the first address byte has bit 0 = 0, whatever the requested direction.
- R3: The subaddress bytes follow the first address byte without START. With `sub_len` = 2 the order is `sub_addr[15:8]` and then `sub_addr[7:0]`. With `sub_len` = 1 only `sub_addr[7:0]` is sent.
- R4: For a read with a subaddress, the command after the last subaddress byte carries START (a repeated START) and the byte `{dev_addr, 1}`.
- R5: For a write, the data bytes follow the last address or subaddress byte without START, in stream order, and only the final data byte carries STOP.
- R6: For a read, each data command is a receive. Only the final one carries NAK and STOP. The received bytes leave on the read stream in order, and the transaction ends with phase done (1) and residue 0.
- R7: A NAK reported for an address byte or a write data byte ends the transaction in phase done with error 0 and no further command. The residue is the number of data bytes not acknowledged.
- R8: A read also ends after delivering the current byte when that byte completes with the NAK flag set or with both `eng_sda_in` and `eng_scl_in` high. The residue is the requested count minus the bytes delivered.
- R9: Arbitration loss, bus error and unexpected STOP on a completed byte end the transaction in phase failed (2), with error code 1, 2 and 3 respectively, in that priority. Phase codes are: idle 0, done 1, failed 2, busy 3, address 4, subaddress 5, read 6, write 7, halting 8. A done transaction reports error 0.
- R10: When an engine command stays outstanding for `timeout_cycles` cycles (0 disables the timeout), the error code becomes 4. If `eng_unit_busy` is high, the sequencer enters halting (8), pulses `eng_abort`, and moves to failed once `eng_unit_busy` falls. Otherwise it goes straight to failed with no abort.
- R11: A `byte_count` above 8192 is treated as 8192, and the residue is counted from that limit.
- R12: If `eng_bus_busy` or `eng_unit_busy` is high when a start is accepted, `eng_unit_reset` pulses for exactly one cycle (phase busy), and the transaction then proceeds normally.
- R13: `rd_valid` and `rd_data` hold while `rd_ready` is low. A write data byte is consumed only on a cycle where `wr_valid` and `wr_ready` are both high.
- R14: A `byte_count` of 0 gives an addressing-only write. The address and subaddress bytes go out with bit 0 = 0, the last of them carries STOP, and no data command follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transaction (accepted in idle, done or failed) |
| dev_addr | input | 7 | Target device address |
| rd_req | input | 1 | 1 = read, 0 = write |
| sub_len | input | 2 | Subaddress length in bytes (0 to 2) |
| sub_addr | input | 16 | Subaddress value |
| byte_count | input | 14 | Data bytes requested |
| timeout_cycles | input | 16 | Per-command timeout in cycles, 0 = off |
| wr_data | input | 8 | Write stream byte |
| wr_valid | input | 1 | Write stream valid |
| wr_ready | output | 1 | Write stream ready |
| rd_data | output | 8 | Read stream byte |
| rd_valid | output | 1 | Read stream valid |
| rd_ready | input | 1 | Read stream ready |
| eng_go | output | 1 | One-cycle command strobe to the byte engine |
| eng_tx_byte | output | 8 | Byte to transmit |
| eng_cmd_start | output | 1 | Precede the byte with START |
| eng_cmd_stop | output | 1 | Follow the byte with STOP |
| eng_cmd_read | output | 1 | Receive a byte instead of sending |
| eng_cmd_nak | output | 1 | Answer the received byte with NAK |
| eng_abort | output | 1 | Send STOP without data |
| eng_unit_reset | output | 1 | Reset the byte engine |
| eng_done | input | 1 | Byte command finished |
| eng_rx_byte | input | 8 | Received byte |
| eng_nak_rcvd | input | 1 | NAK seen on this byte |
| eng_arb_lost | input | 1 | Arbitration lost |
| eng_bus_err | input | 1 | Bus error |
| eng_stop_seen | input | 1 | Unexpected STOP |
| eng_sda_in | input | 1 | Sampled data line |
| eng_scl_in | input | 1 | Sampled clock line |
| eng_bus_busy | input | 1 | Bus held between START and STOP |
| eng_unit_busy | input | 1 | Engine mid-transfer |
| phase | output | 4 | Current phase code |
| residue | output | 14 | Data bytes not transferred |
| err_code | output | 3 | Failure cause |

## Verification
The bench sweeps every combination of direction, subaddress length 0 to 2 and byte counts 0 to 3, with stalls on both streams. This catches a design that sends the read bit on the first byte of an offset read, swaps the offset bytes, omits the repeated START, or misplaces STOP and NAK. Further cases make the slave refuse the address or a middle data byte, which would expose an off-by-one residue. They also end a read through an idle bus, a stuck bus at start, and each error flag, where a wrong priority shows up as the wrong code. A hung command is run with and without the engine still busy: a design that skips the abort, or aborts without need, is reported, as is a count above 8192 that is not clamped.

// File: rtl/i2c_seq_pkg.sv
`timescale 1ns/1ps
package i2c_seq_pkg;
  typedef enum logic [3:0] {
    PH_IDLE    = 4'd0,
    PH_DONE    = 4'd1,
    PH_FAILED  = 4'd2,
    PH_BUSY    = 4'd3,
    PH_ADDRESS = 4'd4,
    PH_SUBADDR = 4'd5,
    PH_READ    = 4'd6,
    PH_WRITE   = 4'd7,
    PH_HALTING = 4'd8
  } phase_t;

  typedef enum logic [2:0] {
    ERR_NONE    = 3'd0,
    ERR_ARB     = 3'd1,
    ERR_BUS     = 3'd2,
    ERR_ABORTED = 3'd3,
    ERR_TIMEOUT = 3'd4
  } err_t;
endpackage

// File: rtl/i2c_seq_timer.sv
`timescale 1ns/1ps
module i2c_seq_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         clear,
  input  logic [W-1:0] limit,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                       cnt_q <= '0;
    else if (clear)                   cnt_q <= '0;
    else if (run && (cnt_q != '1))    cnt_q <= cnt_q + 1'b1;
  end

  assign expired = run && (limit != '0) && (cnt_q >= limit);

  assert_clear_restarts_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !expired);
endmodule

// File: rtl/i2c_seq_count.sv
`timescale 1ns/1ps
module i2c_seq_count #(
  parameter int MAX = 8192,
  parameter int W   = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] remain,
  output logic         is_zero,
  output logic         is_one
);
  localparam logic [W-1:0] MAXV = W'(MAX);
  logic [W-1:0] rem_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    rem_q <= '0;
    else if (load) rem_q <= (load_val > MAXV) ? MAXV : load_val;
    else if (dec)  rem_q <= rem_q - 1'b1;
  end

  assign remain  = rem_q;
  assign is_zero = (rem_q == '0);
  assign is_one  = (rem_q == W'(1));

  assert_within_max_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rem_q <= MAXV);
  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load) |-> (rem_q != '0));
endmodule

// File: rtl/i2c_seq_subaddr.sv
`timescale 1ns/1ps
module i2c_seq_subaddr #(
  parameter int MAXB = 2,
  localparam int LW  = $clog2(MAXB + 1),
  localparam int VW  = 8 * MAXB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [LW-1:0] len,
  input  logic [VW-1:0] val,
  input  logic          adv,
  output logic [7:0]    cur_byte,
  output logic [LW-1:0] left
);
  localparam logic [LW-1:0] MAXL = LW'(MAXB);
  logic [VW-1:0] sh_q;
  logic [LW-1:0] left_q;
  logic [LW-1:0] len_c;

  assign len_c = (len > MAXL) ? MAXL : len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (load) begin
      sh_q   <= val << (8 * (MAXB - int'(len_c)));
      left_q <= len_c;
    end else if (adv) begin
      sh_q   <= sh_q << 8;
      left_q <= left_q - 1'b1;
    end
  end

  assign cur_byte = sh_q[VW-1 -: 8];
  assign left     = left_q;

  assert_adv_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load) |-> (left_q != '0));
endmodule

// File: rtl/i2c_txn_seq.sv
`timescale 1ns/1ps
module i2c_txn_seq
  import i2c_seq_pkg::*;
#(
  parameter int MAX_BYTES = 8192,
  parameter int SUB_MAX   = 2,
  parameter int TO_W      = 16,
  localparam int CNT_W    = $clog2(MAX_BYTES + 1),
  localparam int SUB_LW   = $clog2(SUB_MAX + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [6:0]           dev_addr,
  input  logic                 rd_req,
  input  logic [SUB_LW-1:0]    sub_len,
  input  logic [8*SUB_MAX-1:0] sub_addr,
  input  logic [CNT_W-1:0]     byte_count,
  input  logic [TO_W-1:0]      timeout_cycles,
  input  logic [7:0]           wr_data,
  input  logic                 wr_valid,
  output logic                 wr_ready,
  output logic [7:0]           rd_data,
  output logic                 rd_valid,
  input  logic                 rd_ready,
  output logic                 eng_go,
  output logic [7:0]           eng_tx_byte,
  output logic                 eng_cmd_start,
  output logic                 eng_cmd_stop,
  output logic                 eng_cmd_read,
  output logic                 eng_cmd_nak,
  output logic                 eng_abort,
  output logic                 eng_unit_reset,
  input  logic                 eng_done,
  input  logic [7:0]           eng_rx_byte,
  input  logic                 eng_nak_rcvd,
  input  logic                 eng_arb_lost,
  input  logic                 eng_bus_err,
  input  logic                 eng_stop_seen,
  input  logic                 eng_sda_in,
  input  logic                 eng_scl_in,
  input  logic                 eng_bus_busy,
  input  logic                 eng_unit_busy,
  output logic [3:0]           phase,
  output logic [CNT_W-1:0]     residue,
  output logic [2:0]           err_code
);
  phase_t     phase_q;
  err_t       err_q, fail_code;
  logic       pend_q, abort_q, rw_q, addr_rd_q;
  logic [6:0] addr_q;
  logic [7:0] rd_q;
  logic       rd_v_q, rd_last_q;

  logic       idle_like, working, start_acc, fail_now, ok_done;
  logic       tmr_run, tmr_clear, tmr_exp;
  logic       cnt_dec, cnt_zero, cnt_one;
  logic [CNT_W-1:0] cnt_rem;
  logic       sub_adv;
  logic [7:0] sub_byte;
  logic [SUB_LW-1:0] sub_left;
  logic       want_rd;

  assign idle_like = (phase_q == PH_IDLE) || (phase_q == PH_DONE) || (phase_q == PH_FAILED);
  assign working   = (phase_q == PH_ADDRESS) || (phase_q == PH_SUBADDR) ||
                     (phase_q == PH_READ) || (phase_q == PH_WRITE);
  assign start_acc = idle_like && start;
  assign want_rd   = rd_req && (byte_count != '0);

  // failure detection, priority arbitration > bus error > unexpected stop > timeout
  always_comb begin
    fail_now  = 1'b0;
    fail_code = ERR_NONE;
    if (working) begin
      if (pend_q && eng_done) begin
        if (eng_arb_lost)       begin fail_now = 1'b1; fail_code = ERR_ARB;     end
        else if (eng_bus_err)   begin fail_now = 1'b1; fail_code = ERR_BUS;     end
        else if (eng_stop_seen) begin fail_now = 1'b1; fail_code = ERR_ABORTED; end
      end else if (tmr_exp) begin
        fail_now  = 1'b1;
        fail_code = ERR_TIMEOUT;
      end
    end
  end

  assign ok_done = working && pend_q && eng_done && !fail_now;

  // engine command generation
  always_comb begin
    eng_go        = 1'b0;
    eng_tx_byte   = 8'h00;
    eng_cmd_start = 1'b0;
    eng_cmd_stop  = 1'b0;
    eng_cmd_read  = 1'b0;
    eng_cmd_nak   = 1'b0;
    wr_ready      = 1'b0;
    case (phase_q)
      PH_ADDRESS: begin
        eng_go        = !pend_q;
        eng_tx_byte   = {addr_q, addr_rd_q};
        eng_cmd_start = 1'b1;
        eng_cmd_stop  = !addr_rd_q && (sub_left == '0) && cnt_zero;
      end
      PH_SUBADDR: begin
        eng_go       = !pend_q;
        eng_tx_byte  = sub_byte;
        eng_cmd_stop = (sub_left == SUB_LW'(1)) && cnt_zero;
      end
      PH_WRITE: begin
        wr_ready     = !pend_q;
        eng_go       = !pend_q && wr_valid;
        eng_tx_byte  = wr_data;
        eng_cmd_stop = cnt_one;
      end
      PH_READ: begin
        eng_go       = !pend_q && !rd_v_q;
        eng_cmd_read = 1'b1;
        eng_cmd_nak  = cnt_one;
        eng_cmd_stop = cnt_one;
      end
      default: ;
    endcase
  end

  assign tmr_run   = pend_q || (phase_q == PH_HALTING);
  assign tmr_clear = eng_go || ok_done || start_acc || fail_now;
  assign sub_adv   = ok_done && (phase_q == PH_SUBADDR) && !eng_nak_rcvd;
  assign cnt_dec   = ok_done && (((phase_q == PH_WRITE) && !eng_nak_rcvd) || (phase_q == PH_READ));

  i2c_seq_timer #(.W(TO_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(tmr_run), .clear(tmr_clear),
    .limit(timeout_cycles), .expired(tmr_exp)
  );

  i2c_seq_count #(.MAX(MAX_BYTES), .W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .load(start_acc), .load_val(byte_count),
    .dec(cnt_dec), .remain(cnt_rem), .is_zero(cnt_zero), .is_one(cnt_one)
  );

  i2c_seq_subaddr #(.MAXB(SUB_MAX)) u_sub (
    .clk(clk), .rst_n(rst_n), .load(start_acc), .len(sub_len), .val(sub_addr),
    .adv(sub_adv), .cur_byte(sub_byte), .left(sub_left)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      err_q     <= ERR_NONE;
      pend_q    <= 1'b0;
      abort_q   <= 1'b0;
      rw_q      <= 1'b0;
      addr_rd_q <= 1'b0;
      addr_q    <= '0;
      rd_q      <= '0;
      rd_v_q    <= 1'b0;
      rd_last_q <= 1'b0;
    end else begin
      abort_q <= 1'b0;
      if (idle_like) begin
        if (start) begin
          addr_q    <= dev_addr;
          rw_q      <= want_rd;
          addr_rd_q <= want_rd && (sub_len == '0);
          err_q     <= ERR_NONE;
          pend_q    <= 1'b0;
          rd_v_q    <= 1'b0;
          phase_q   <= (eng_bus_busy || eng_unit_busy) ? PH_BUSY : PH_ADDRESS;
        end
      end else if (phase_q == PH_BUSY) begin
        phase_q <= PH_ADDRESS;
      end else if (phase_q == PH_HALTING) begin
        if (!eng_unit_busy || tmr_exp) phase_q <= PH_FAILED;
      end else if (fail_now) begin
        pend_q <= 1'b0;
        err_q  <= fail_code;
        if (eng_unit_busy) begin
          phase_q <= PH_HALTING;
          abort_q <= 1'b1;
        end else begin
          phase_q <= PH_FAILED;
        end
      end else begin
        if (eng_go) pend_q <= 1'b1;
        if (ok_done) begin
          pend_q <= 1'b0;
          case (phase_q)
            PH_ADDRESS: begin
              if (eng_nak_rcvd)          phase_q <= PH_DONE;
              else if (addr_rd_q)        phase_q <= PH_READ;
              else if (sub_left != '0)   phase_q <= PH_SUBADDR;
              else if (cnt_zero)         phase_q <= PH_DONE;
              else                       phase_q <= PH_WRITE;
            end
            PH_SUBADDR: begin
              if (eng_nak_rcvd) phase_q <= PH_DONE;
              else if (sub_left == SUB_LW'(1)) begin
                if (cnt_zero) phase_q <= PH_DONE;
                else if (rw_q) begin
                  addr_rd_q <= 1'b1;
                  phase_q   <= PH_ADDRESS;
                end else phase_q <= PH_WRITE;
              end
            end
            PH_WRITE: begin
              if (eng_nak_rcvd || cnt_one) phase_q <= PH_DONE;
            end
            PH_READ: begin
              rd_q      <= eng_rx_byte;
              rd_v_q    <= 1'b1;
              rd_last_q <= cnt_one || eng_nak_rcvd || (eng_sda_in && eng_scl_in);
            end
            default: ;
          endcase
        end
        if ((phase_q == PH_READ) && rd_v_q && rd_ready) begin
          rd_v_q <= 1'b0;
          if (rd_last_q) phase_q <= PH_DONE;
        end
      end
    end
  end

  assign rd_data        = rd_q;
  assign rd_valid       = rd_v_q;
  assign eng_abort      = abort_q;
  assign eng_unit_reset = (phase_q == PH_BUSY);
  assign phase          = phase_q;
  assign residue        = cnt_rem;
  assign err_code       = err_q;

  assert_one_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_go |=> !eng_go);
  assert_rd_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
  assert_done_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DONE) |-> (err_code == 3'd0));
  assert_reset_once_R12: assert property (@(posedge clk) disable iff (!rst_n)
    eng_unit_reset |=> !eng_unit_reset);
  assert_abort_entry_R10: assert property (@(posedge clk) disable iff (!rst_n)
    eng_abort |-> (phase_q == PH_HALTING));
endmodule

// File: tb/tb_i2c_txn_seq.sv
`timescale 1ns/1ps
module tb_i2c_txn_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic start = 0, rd_req = 0, wr_valid = 0, rd_ready = 0;
  logic [6:0] dev_addr = 0;
  logic [1:0] sub_len = 0;
  logic [15:0] sub_addr = 0;
  logic [13:0] byte_count = 0;
  logic [15:0] timeout_cycles = 16'd100;
  logic [7:0] wr_data = 0;
  logic wr_ready, rd_valid;
  logic [7:0] rd_data;
  logic eng_go, eng_cmd_start, eng_cmd_stop, eng_cmd_read, eng_cmd_nak, eng_abort, eng_unit_reset;
  logic [7:0] eng_tx_byte;
  logic eng_done = 0, eng_nak_rcvd = 0, eng_arb_lost = 0, eng_bus_err = 0, eng_stop_seen = 0;
  logic eng_sda_in = 0, eng_scl_in = 0;
  logic [7:0] eng_rx_byte = 0;
  logic eng_bus_busy, eng_unit_busy;
  logic [3:0] phase;
  logic [13:0] residue;
  logic [2:0] err_code;

  i2c_txn_seq dut (.*);

  int total = 0, fails = 0;
  // engine model controls
  int nak_idx = -1, berr_idx = -1, arb_idx = -1, stp_idx = -1, idle_idx = -1, hang_idx = -1;
  logic ub_want = 0, bb_want = 0, clr_log = 0;
  logic abort_clr = 0, reset_clr = 0, saw_halt = 0;
  int ncmd = 0, cur = 0, lat = 0, nrx = 0, wr_idx = 0, wr_lim = 0, aborts = 0, resets = 0, cyc = 0;
  logic [7:0] lbyte [0:63];
  logic [3:0] lflag [0:63];
  logic [7:0] rbuf [0:63];

  assign eng_unit_busy = ub_want & ~abort_clr;
  assign eng_bus_busy  = bb_want & ~reset_clr;

  function automatic logic [7:0] rxv(input int k); return 8'(k * 29 + 7); endfunction
  function automatic logic [7:0] wdv(input int j); return 8'(j * 13 + 5); endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    eng_done <= 1'b0;
    if (clr_log) begin
      ncmd <= 0; nrx <= 0; wr_idx <= 0; aborts <= 0; resets <= 0;
      abort_clr <= 0; reset_clr <= 0; saw_halt <= 0; lat <= 0;
    end else begin
      if (phase == 4'd8) saw_halt <= 1'b1;
      if (eng_unit_reset) begin resets <= resets + 1; reset_clr <= 1'b1; end
      if (eng_abort) aborts <= aborts + 1;
      if (aborts > 0 && !abort_clr && !eng_abort) abort_clr <= 1'b1;
      if (wr_valid && wr_ready) wr_idx <= wr_idx + 1;
      if (rd_valid && rd_ready) begin
        if (nrx < 64) rbuf[nrx] <= rd_data;
        nrx <= nrx + 1;
      end
      if (eng_go) begin
        if (ncmd < 64) begin
          lbyte[ncmd] <= eng_tx_byte;
          lflag[ncmd] <= {eng_cmd_start, eng_cmd_stop, eng_cmd_read, eng_cmd_nak};
        end
        cur <= ncmd; ncmd <= ncmd + 1; lat <= 3;
      end else if (lat > 0) begin
        lat <= lat - 1;
        if (lat == 1 && cur != hang_idx) begin
          eng_done      <= 1'b1;
          eng_rx_byte   <= rxv(cur);
          eng_nak_rcvd  <= (cur == nak_idx);
          eng_bus_err   <= (cur == berr_idx);
          eng_arb_lost  <= (cur == arb_idx);
          eng_stop_seen <= (cur == stp_idx);
          eng_sda_in    <= (cur == idle_idx);
          eng_scl_in    <= (cur == idle_idx);
        end
      end
    end
  end

  always @(negedge clk) begin
    wr_valid <= (wr_idx < wr_lim) && (cyc % 4 != 1);
    wr_data  <= wdv(wr_idx);
    rd_ready <= (cyc % 3 != 0);
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic reset_model();
    nak_idx = -1; berr_idx = -1; arb_idx = -1; stp_idx = -1; idle_idx = -1; hang_idx = -1;
    ub_want = 0; bb_want = 0;
  endtask

  task automatic run_txn(input bit rd, input int sl, input int cnt, input logic [6:0] a, input logic [15:0] s);
    int n;
    @(negedge clk); clr_log = 1;
    @(negedge clk); clr_log = 0;
    rd_req = rd; sub_len = 2'(sl); dev_addr = a; sub_addr = s; byte_count = 14'(cnt);
    wr_lim = cnt; start = 1;
    @(negedge clk); start = 0;
    n = 0;
    while (!(phase == 4'd1 || phase == 4'd2) && n < 40000) begin @(negedge clk); n++; end
    if (n >= 40000) chk(0, "WD", "transaction hang", n, 0);
    @(negedge clk);
  endtask

  task automatic sweep_one(input bit rd, input int sl, input int cnt, input int i);
    logic [6:0] a; logic [15:0] s;
    logic [7:0] eb [0:15]; logic [3:0] ef [0:15];
    int k, bad, pre; bit er; string tag;
    a = 7'h50 ^ 7'(i); s = 16'hA5C3 + 16'(i * 257);
    run_txn(rd, sl, cnt, a, s);
    er = rd && (cnt != 0);
    k = 0;
    eb[k] = {a, (sl == 0) ? er : 1'b0}; ef[k] = {1'b1, (sl == 0 && cnt == 0), 2'b00}; k++;
    for (int b = sl - 1; b >= 0; b--) begin
      eb[k] = 8'(s >> (8 * b)); ef[k] = {1'b0, (b == 0 && cnt == 0), 2'b00}; k++;
    end
    if (er && sl > 0) begin eb[k] = {a, 1'b1}; ef[k] = 4'b1000; k++; end
    pre = k;
    for (int j = 0; j < cnt; j++) begin
      if (er) begin eb[k] = 8'h00; ef[k] = {1'b0, (j == cnt - 1), 1'b1, (j == cnt - 1)}; end
      else begin eb[k] = wdv(j); ef[k] = {1'b0, (j == cnt - 1), 2'b00}; end
      k++;
    end
    if (cnt == 0) tag = "R14";
    else if (er && sl > 0) tag = "R4";
    else if (er) tag = "R6";
    else if (sl > 0) tag = "R3";
    else tag = "R5";
    chk(ncmd == k, tag, "command count", ncmd, k);
    bad = 0;
    for (int c = 0; c < k && c < ncmd; c++)
      if (lflag[c] != ef[c] || (!ef[c][1] || !ef[c][0] ? (ef[c][1] ? 1'b0 : lbyte[c] != eb[c]) : 1'b0)) bad++;
    chk(bad == 0, tag, "command sequence mismatches", bad, 0);
    chk(lbyte[0] == eb[0], (sl > 0) ? "R2" : "R1", "first address byte", lbyte[0], eb[0]);
    chk(phase == 4'd1 && err_code == 0, tag, "final phase", phase, 1);
    chk(residue == 0, tag, "residue", residue, 0);
    if (er) begin
      bad = 0;
      for (int j = 0; j < cnt; j++) if (rbuf[j] != rxv(pre + j)) bad++;
      chk(nrx == cnt && bad == 0, "R13", "read stream bytes", nrx, cnt);
    end
  endtask

  initial begin
    #(10 * 190000);
    fails++; total++;
    $display("FAIL WD watchdog expired: actual 1 expected 0");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(phase == 0 && residue == 0 && err_code == 0, "R9", "reset phase", phase, 0);
    chk(!eng_go && !rd_valid && !eng_abort && !eng_unit_reset, "R9", "reset outputs quiet", eng_go, 0);
    rst_n = 1;
    @(negedge clk);

    // near-exhaustive sweep: direction x subaddress length x count
    for (int rd = 0; rd < 2; rd++)
      for (int sl = 0; sl < 3; sl++)
        for (int cnt = 0; cnt < 4; cnt++)
          sweep_one(rd[0], sl, cnt, rd * 12 + sl * 4 + cnt);

    // R7: slave refuses second data byte of four
    reset_model(); nak_idx = 2;
    run_txn(0, 0, 4, 7'h21, 0);
    chk(phase == 1 && err_code == 0, "R7", "write nak phase", phase, 1);
    chk(residue == 3, "R7", "write nak residue", residue, 3);
    chk(ncmd == 3, "R7", "no command after nak", ncmd, 3);

    // R7: address refused
    reset_model(); nak_idx = 0;
    run_txn(0, 1, 2, 7'h22, 16'h0011);
    chk(phase == 1 && residue == 2 && ncmd == 1, "R7", "address nak residue", residue, 2);

    // R8: idle bus ends read after second byte
    reset_model(); idle_idx = 2;
    run_txn(1, 0, 5, 7'h23, 0);
    chk(phase == 1 && nrx == 2, "R8", "idle read bytes delivered", nrx, 2);
    chk(residue == 3, "R8", "idle read residue", residue, 3);

    // R8: nak flag ends read after third byte
    reset_model(); nak_idx = 3;
    run_txn(1, 0, 6, 7'h24, 0);
    chk(nrx == 3 && residue == 3, "R8", "nak read residue", residue, 3);

    // R9: error codes
    reset_model(); arb_idx = 0; berr_idx = 0;
    run_txn(0, 0, 2, 7'h25, 0);
    chk(phase == 2 && err_code == 1, "R9", "arbitration priority code", err_code, 1);
    reset_model(); berr_idx = 1; stp_idx = 1;
    run_txn(0, 1, 2, 7'h26, 16'h0033);
    chk(phase == 2 && err_code == 2, "R9", "bus error code", err_code, 2);
    reset_model(); stp_idx = 2;
    run_txn(1, 0, 3, 7'h27, 0);
    chk(phase == 2 && err_code == 3, "R9", "unexpected stop code", err_code, 3);

    // R10: timeout with engine busy -> halting + abort
    reset_model(); hang_idx = 1; timeout_cycles = 16'd40;
    fork
      begin repeat (4) @(negedge clk); ub_want = 1; end
      run_txn(0, 0, 2, 7'h28, 0);
    join
    chk(phase == 2 && err_code == 4, "R10", "timeout code busy", err_code, 4);
    chk(aborts == 1 && saw_halt, "R10", "abort issued via halting", aborts, 1);
    // R10: timeout with engine idle -> straight to failed
    reset_model(); hang_idx = 0;
    run_txn(1, 0, 2, 7'h29, 0);
    chk(phase == 2 && err_code == 4, "R10", "timeout code idle", err_code, 4);
    chk(aborts == 0 && !saw_halt, "R10", "no abort when idle", aborts, 0);
    timeout_cycles = 16'd100;

    // R11: count above limit clamped
    reset_model(); nak_idx = 1;
    run_txn(0, 0, 10000, 7'h2A, 0);
    chk(residue == 8192, "R11", "clamped residue", residue, 8192);

    // R12: stuck bus at start
    reset_model(); bb_want = 1;
    run_txn(0, 0, 2, 7'h2B, 0);
    chk(resets == 1, "R12", "unit reset pulses", resets, 1);
    chk(phase == 1 && ncmd == 3 && lbyte[0] == {7'h2B, 1'b0}, "R12", "proceeds after reset", ncmd, 3);
    bb_want = 0;

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule